// File: doc/BRIEF.md
# Field Sync Broad-Pulse Detector

This block sits on a stream of 8-bit digitised composite video and sorts each sync pulse into one of two kinds. Samples sit near 0 at sync tip, near 60 at black and near 200 at white. When the stream falls from above a programmable slice level to at or below it, the block opens a fixed-length window and adds up every valid sample that arrives in it. The window is longer than a line sync and shorter than a field-sync broad pulse. A broad pulse keeps the signal at sync tip for the whole window, so its total stays small. A line sync returns to black partway through, so its total grows large. When the window closes, the total is compared with a run-time threshold. Because the test is on summed energy, a few dropout spikes inside a broad pulse do not break detection.

After a broad pulse has been declared, the block can ignore sync edges for a programmable number of valid samples. This holds it off until the next field sync is due, so stray edges in the active picture cannot raise a false field sync. The control is a four-state machine. **IDLE** waits for an edge. The *edge* transition goes to **WINDOW**, or goes straight to **DECIDE** when the window is one sample long. In **WINDOW** the samples are summed, and the *window-done* transition goes to **DECIDE**. **DECIDE** lasts one clock and issues the verdict. From there the *lock* transition goes to **LOCKOUT** when the pulse was broad and the lockout count is non-zero. Otherwise the *release* transition goes back to IDLE. **LOCKOUT** counts down valid samples, and its *expire* transition returns to IDLE.

Top module: `field_sync_detector`

## Requirements
- R1: A sync edge is a valid sample at or below `slice_lvl` whose previous valid sample was above it. An edge in IDLE opens the window, and `window_active` is high from the next clock. The first valid sample after reset can never be an edge.
- R2: The window holds exactly WIN_LEN valid samples, and the edge sample is the first of them. Cycles with `smp_valid` low neither close the window nor count toward its length.
- R3: An edge that arrives while the window is open is ignored. The window is neither restarted nor extended.
- R4: The accumulator is ACC_W bits wide (18 by default). It is loaded with the edge sample and then adds each later valid window sample. It saturates at 2^ACC_W-1 and never wraps.
- R5: In the clock after the last window sample is accepted, `broad_pulse` is high for exactly one cycle if the total is less than or equal to `thresh`. A total equal to the threshold counts as broad.
- R6: In that same cycle, `line_pulse` is high instead when the total exceeds `thresh`. The two outputs are never high together.
- R7: After a broad pulse with a non-zero `lock_len`, `lockout_active` stays high for exactly `lock_len` valid samples that follow the DECIDE cycle. Edges during lockout open no window.
- R8: When `lock_len` is zero, a broad pulse returns the block to IDLE with no lockout.
- R9: A synchronous active-high `rst` clears the state, the counters, the accumulator and the edge history. All four outputs are low in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Qualifies `smp_data` in this cycle |
| smp_data | input | SAMPLE_W (8) | Unsigned video sample |
| slice_lvl | input | SAMPLE_W (8) | Sync slice level for edge detection |
| thresh | input | ACC_W (18) | Broad-pulse threshold on the window total |
| lock_len | input | LOCK_W (20) | Lockout length in valid samples; 0 disables it |
| window_active | output | 1 | High while in WINDOW |
| lockout_active | output | 1 | High while in LOCKOUT |
| broad_pulse | output | 1 | One-cycle flag: field-sync broad pulse |
| line_pulse | output | 1 | One-cycle flag: ordinary sync pulse |

## Verification
The bench places a dropout spike inside a broad pulse, so the sample after the spike forms a second edge mid-window. A design that restarted the window on it would report its verdict late. It sets the threshold exactly equal to a known window total and then one below it, which catches a strict-versus-inclusive compare. A small second instance is driven with full-scale samples until its sum overflows. A wrapping accumulator there would report a broad pulse where a saturating one reports a line pulse. The lockout boundary is probed one sample before and at expiry, with edges injected in between, and zero lockout is exercised. Invalid cycles are scattered through every window, so a counter that advanced on them would close early.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WINDOW,
        ST_DECIDE,
        ST_LOCKOUT
    } fsd_state_e;

endpackage

// File: rtl/fsd_edge_slicer.sv
module fsd_edge_slicer #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-1:0] slice_lvl,
    output logic                edge_evt
);

    logic was_above_q;
    logic now_below;

    assign now_below = (smp_data <= slice_lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            was_above_q <= 1'b0;
        end else if (smp_valid) begin
            was_above_q <= !now_below;
        end
    end

    always_comb begin
        edge_evt = smp_valid && was_above_q && now_below;
    end

endmodule

// File: rtl/fsd_window_accum.sv
module fsd_window_accum #(
    parameter int SAMPLE_W = 8,
    parameter int WIN_LEN  = 405,
    parameter int ACC_W    = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                win_start,
    input  logic                win_run,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic [ACC_W-1:0]    acc_total,
    output logic                win_done
);

    localparam int CNT_W = $clog2(WIN_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIN_LEN - 1);
    localparam logic [ACC_W-1:0] ACC_MAX  = {ACC_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   wide_sum;
    logic [ACC_W-1:0] sat_sum;
    logic [ACC_W-1:0] smp_ext;

    assign smp_ext  = {{(ACC_W - SAMPLE_W){1'b0}}, smp_data};
    assign wide_sum = {1'b0, acc_q} + {1'b0, smp_ext};
    assign sat_sum  = wide_sum[ACC_W] ? ACC_MAX : wide_sum[ACC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (win_start) begin
            cnt_q <= CNT_W'(1);
            acc_q <= smp_ext;
        end else if (win_run && smp_valid) begin
            cnt_q <= cnt_q + CNT_W'(1);
            acc_q <= sat_sum;
        end
    end

    generate
        if (WIN_LEN == 1) begin : g_single
            assign win_done = win_start;
        end else begin : g_multi
            assign win_done = win_run && smp_valid && (cnt_q == LAST_CNT);
        end
    endgenerate

    assign acc_total = acc_q;

endmodule

// File: rtl/fsd_lockout_timer.sv
module fsd_lockout_timer #(
    parameter int LOCK_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_load,
    input  logic [LOCK_W-1:0] lock_len,
    input  logic              lock_run,
    input  logic              smp_valid,
    output logic              lock_expire
);

    logic [LOCK_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (lock_load) begin
            remain_q <= lock_len;
        end else if (lock_run && smp_valid && remain_q != '0) begin
            remain_q <= remain_q - LOCK_W'(1);
        end
    end

    assign lock_expire = lock_run && smp_valid && (remain_q == LOCK_W'(1));

endmodule

// File: rtl/field_sync_detector.sv
module field_sync_detector
    import fsd_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int WIN_LEN  = 405,
    parameter int ACC_W    = 18,
    parameter int LOCK_W   = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-1:0] slice_lvl,
    input  logic [ACC_W-1:0]    thresh,
    input  logic [LOCK_W-1:0]   lock_len,
    output logic                window_active,
    output logic                lockout_active,
    output logic                broad_pulse,
    output logic                line_pulse
);

    fsd_state_e       state_q;
    fsd_state_e       state_d;
    logic             edge_evt;
    logic             win_start;
    logic             win_run;
    logic             win_done;
    logic [ACC_W-1:0] acc_total;
    logic             is_broad;
    logic             lock_load;
    logic             lock_run;
    logic             lock_expire;

    fsd_edge_slicer #(
        .SAMPLE_W (SAMPLE_W)
    ) u_slicer (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .slice_lvl (slice_lvl),
        .edge_evt  (edge_evt)
    );

    fsd_window_accum #(
        .SAMPLE_W (SAMPLE_W),
        .WIN_LEN  (WIN_LEN),
        .ACC_W    (ACC_W)
    ) u_accum (
        .clk       (clk),
        .rst       (rst),
        .win_start (win_start),
        .win_run   (win_run),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .acc_total (acc_total),
        .win_done  (win_done)
    );

    fsd_lockout_timer #(
        .LOCK_W (LOCK_W)
    ) u_lock (
        .clk         (clk),
        .rst         (rst),
        .lock_load   (lock_load),
        .lock_len    (lock_len),
        .lock_run    (lock_run),
        .smp_valid   (smp_valid),
        .lock_expire (lock_expire)
    );

    assign is_broad  = (acc_total <= thresh);
    assign win_start = (state_q == ST_IDLE) && edge_evt;
    assign win_run   = (state_q == ST_WINDOW);
    assign lock_load = (state_q == ST_DECIDE) && is_broad && (lock_len != '0);
    assign lock_run  = (state_q == ST_LOCKOUT);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: edge, window-done, lock, release, expire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (edge_evt) begin
                    state_d = win_done ? ST_DECIDE : ST_WINDOW;
                end
            end
            ST_WINDOW: begin
                if (win_done) begin
                    state_d = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                state_d = lock_load ? ST_LOCKOUT : ST_IDLE;
            end
            ST_LOCKOUT: begin
                if (lock_expire) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        window_active  = 1'b0;
        lockout_active = 1'b0;
        broad_pulse    = 1'b0;
        line_pulse     = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_WINDOW:  window_active = 1'b1;
            ST_DECIDE: begin
                broad_pulse = is_broad;
                line_pulse  = !is_broad;
            end
            ST_LOCKOUT: lockout_active = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/fsd_checker.sv
module fsd_checker #(
    parameter int WIN_LEN = 405,
    parameter int LOCK_W  = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic [LOCK_W-1:0] lock_len,
    input logic              window_active,
    input logic              lockout_active,
    input logic              broad_pulse,
    input logic              line_pulse
);

    AST_WIN_START_VALID: assert property (@(posedge clk) disable iff (rst)
        $rose(window_active) |-> $past(smp_valid)); // R1

    AST_WIN_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (window_active && !smp_valid) |=> window_active); // R2

    AST_VERDICT_AFTER_WIN: assert property (@(posedge clk) disable iff (rst)
        (broad_pulse || line_pulse) |-> ((WIN_LEN == 1) || $past(window_active))); // R5

    AST_BROAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        broad_pulse |=> (!broad_pulse && !line_pulse)); // R5

    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(broad_pulse && line_pulse)); // R6

    AST_LOCK_AFTER_BROAD: assert property (@(posedge clk) disable iff (rst)
        $rose(lockout_active) |-> $past(broad_pulse)); // R7

    AST_LOCK_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (lockout_active && !smp_valid) |=> lockout_active); // R7

    AST_NO_WIN_IN_LOCK: assert property (@(posedge clk) disable iff (rst)
        lockout_active |=> !window_active); // R7

    AST_LOCK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (broad_pulse && lock_len == '0) |=> !lockout_active); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!window_active && !lockout_active && !broad_pulse && !line_pulse)); // R9

endmodule

bind field_sync_detector fsd_checker #(
    .WIN_LEN (WIN_LEN),
    .LOCK_W  (LOCK_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .smp_valid      (smp_valid),
    .lock_len       (lock_len),
    .window_active  (window_active),
    .lockout_active (lockout_active),
    .broad_pulse    (broad_pulse),
    .line_pulse     (line_pulse)
);

// File: tb/sim_field_sync_detector.sv
module fsd_ref_model #(
    parameter int WIN_LEN = 405,
    parameter int ACC_W   = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       v,
    input  logic [7:0] d,
    input  logic [7:0] sl,
    input  longint     thr,
    input  longint     lk,
    output logic       e_win,
    output logic       e_lock,
    output logic       e_broad,
    output logic       e_line
);
    int     mode;
    bit     above;
    longint cnt, total, remain;
    longint amax;

    initial begin
        mode = 0; above = 0; cnt = 0; total = 0; remain = 0;
        amax = (longint'(1) << ACC_W) - 1;
    end

    always @(posedge clk) begin
        bit edg;
        if (rst) begin
            mode = 0; above = 0; cnt = 0; total = 0; remain = 0;
        end else begin
            edg = v && above && (d <= sl);
            if (v) above = (d > sl);
            case (mode)
                0: if (edg) begin
                    total = d; cnt = 1;
                    mode = (cnt == WIN_LEN) ? 2 : 1;
                end
                1: if (v) begin
                    total = total + d;
                    if (total > amax) total = amax;
                    cnt = cnt + 1;
                    if (cnt == WIN_LEN) mode = 2;
                end
                2: begin
                    if (total <= thr && lk != 0) begin
                        remain = lk; mode = 3;
                    end else mode = 0;
                end
                default: if (v) begin
                    remain = remain - 1;
                    if (remain == 0) mode = 0;
                end
            endcase
        end
    end

    assign e_win   = (mode == 1);
    assign e_lock  = (mode == 3);
    assign e_broad = (mode == 2) && (total <= thr);
    assign e_line  = (mode == 2) && (total > thr);
endmodule

module sim_field_sync_detector;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_data = 8'd60;
    logic [7:0]  slice_lvl = 8'd30;
    logic [17:0] thr0 = 18'd200;
    logic [11:0] thr1 = 12'd4000;
    logic [19:0] lock_len = 20'd0;

    logic w0, l0, b0, n0, w1, l1, b1, n1;
    logic ew0, el0, eb0, en0, ew1, el1, eb1, en1;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    field_sync_detector u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .slice_lvl(slice_lvl), .thresh(thr0), .lock_len(lock_len),
        .window_active(w0), .lockout_active(l0), .broad_pulse(b0), .line_pulse(n0));

    field_sync_detector #(.WIN_LEN(20), .ACC_W(12), .LOCK_W(20)) u1 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .slice_lvl(slice_lvl), .thresh(thr1), .lock_len(lock_len),
        .window_active(w1), .lockout_active(l1), .broad_pulse(b1), .line_pulse(n1));

    fsd_ref_model #(.WIN_LEN(405), .ACC_W(18)) m0 (
        .clk(clk), .rst(rst), .v(smp_valid), .d(smp_data), .sl(slice_lvl),
        .thr(longint'(thr0)), .lk(longint'(lock_len)),
        .e_win(ew0), .e_lock(el0), .e_broad(eb0), .e_line(en0));

    fsd_ref_model #(.WIN_LEN(20), .ACC_W(12)) m1 (
        .clk(clk), .rst(rst), .v(smp_valid), .d(smp_data), .sl(slice_lvl),
        .thr(longint'(thr1)), .lk(longint'(lock_len)),
        .e_win(ew1), .e_lock(el1), .e_broad(eb1), .e_line(en1));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Cycle-by-cycle comparison against the requirement model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk({w0, l0, b0, n0} == {ew0, el0, eb0, en0},
                "R2/R5/R6/R7 u0 {win,lock,broad,line}", {w0, l0, b0, n0}, {ew0, el0, eb0, en0});
            chk({w1, l1, b1, n1} == {ew1, el1, eb1, en1},
                "R4/R5/R6/R7 u1 {win,lock,broad,line}", {w1, l1, b1, n1}, {ew1, el1, eb1, en1});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000 && !done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 190000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic put(input logic [7:0] d, input bit v = 1'b1);
        @(negedge clk);
        smp_valid = v;
        smp_data  = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk({w0, l0, b0, n0, w1, l1, b1, n1} == 8'd0, "R9 outputs after reset",
            {w0, l0, b0, n0, w1, l1, b1, n1}, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Window of 405 valid samples: edge sample 0, spike of 200 at index 100,
    // one invalid gap every 50 samples. Total = 200.
    task automatic spiked_window();
        put(8'd60);
        put(8'd0);
        chk(w0 == 1'b1, "R1 window opens on edge", w0, 1);
        for (int i = 1; i < 405; i++) begin
            if (i % 50 == 0) put(8'd255, 1'b0);
            put((i == 100) ? 8'd200 : 8'd0);
            if (i == 403) chk(w0 == 1'b1, "R2/R3 window still open before last sample", w0, 1);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        do_reset();

        // R1: first valid sample after reset at sync level is not an edge
        put(8'd0);
        chk(w0 == 1'b0, "R1 no edge on first sample after reset", w0, 0);

        // R5 boundary: total equals threshold -> broad; R3 mid-window edge ignored
        thr0 = 18'd200;
        lock_len = 20'd0;
        spiked_window();
        chk(b0 == 1'b1 && n0 == 1'b0, "R3/R5 total==thresh gives broad at window end", {b0, n0}, 2);
        put(8'd60);
        chk(b0 == 1'b0, "R5 broad pulse lasts one cycle", b0, 0);
        chk(l0 == 1'b0, "R8 zero lockout returns to idle", l0, 0);

        // R6: threshold one below the total -> line
        thr0 = 18'd199;
        spiked_window();
        chk(n0 == 1'b1 && b0 == 1'b0, "R6 total>thresh gives line pulse", {b0, n0}, 1);
        put(8'd60);

        // R7: lockout of 50 valid samples with edges inside
        thr0 = 18'd500;
        lock_len = 20'd50;
        spiked_window();
        chk(b0 == 1'b1, "R7 broad before lockout", b0, 1);
        put(8'd60);
        chk(l0 == 1'b1, "R7 lockout entered", l0, 1);
        for (int k = 1; k <= 50; k++) begin
            if (k % 7 == 0) put(8'd60, 1'b0);
            put((k % 2 == 0) ? 8'd0 : 8'd90);
            if (k == 49) chk(l0 == 1'b1 && w0 == 1'b0, "R7 still locked, edges ignored", {l0, w0}, 2);
            if (k == 50) chk(l0 == 1'b0 && w0 == 1'b0, "R7 lockout expires after lock_len", {l0, w0}, 0);
        end
        put(8'd60);
        put(8'd0);
        chk(w0 == 1'b1, "R7 edge after lockout opens window", w0, 1);

        // R4: saturation on the small instance
        do_reset();
        lock_len = 20'd0;
        thr1 = 12'd4000;
        put(8'd60);
        put(8'd0);
        for (int i = 1; i < 20; i++) put(8'd255);
        chk(n1 == 1'b1 && b1 == 1'b0, "R4 saturated total exceeds threshold", {b1, n1}, 1);
        put(8'd60);
        thr1 = 12'd4095;
        put(8'd0);
        for (int i = 1; i < 20; i++) put(8'd255);
        chk(b1 == 1'b1, "R4 saturated total equals max, broad at thresh=max", b1, 1);
        put(8'd60);

        // Random composite-like stream
        do_reset();
        for (int s = 0; s < 140; s++) begin
            int kind;
            thr0 = 18'(500 + $urandom % 3000);
            thr1 = 12'($urandom % 4096);
            lock_len = ($urandom % 4 == 0) ? 20'd0 : 20'(100 + $urandom % 2000);
            slice_lvl = 8'(20 + $urandom % 20);
            kind = $urandom % 3;
            for (int i = 0; i < 20 + int'($urandom % 60); i++)
                put(8'(55 + $urandom % 10), ($urandom % 8) != 0);
            if (kind == 0) begin
                for (int i = 0; i < 63; i++) put(8'($urandom % 6), ($urandom % 8) != 0);
                for (int i = 0; i < 100 + int'($urandom % 200); i++)
                    put(8'(60 + $urandom % 141), ($urandom % 8) != 0);
            end else begin
                for (int i = 0; i < 430; i++)
                    put(($urandom % 64 == 0) ? 8'($urandom % 256) : 8'($urandom % 4),
                        ($urandom % 8) != 0);
                for (int i = 0; i < 30; i++) put(8'd60, ($urandom % 8) != 0);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule